// File: doc/BRIEF.md
# Stereo Audio Error Concealment Interpolator

This block sits in a digital audio path after error correction and hides samples that the corrector could not repair. Once per word clock it takes one left/right pair of 16-bit two's complement samples, each with its own flag marking the sample as bad. It returns the same pair stream one word clock later. That delay means the following sample and its flag are already known when the block decides what to send for the current sample.

Each channel keeps its own state. A lone bad sample is replaced by the midpoint of the good samples on either side of it. In a run of bad samples, every sample except the last is replaced by the most recent good value. The last one is replaced by the midpoint between that held value and the good sample that ends the run. A data-mode input turns concealment off, so non-audio content passes through bit for bit.

A two-bit report sums up, over a frame window, what the block did to the stream. The window starts at a frame-start strobe.

Top module: `conceal_interp`

## Requirements
- R1: A pair presented with `smp_stb` high causes `out_stb` to be high for exactly one cycle on the next clock. The pair on the output is the one received at the previous strobe. The output samples do not change in cycles without a strobe.
- R2: A sample whose flag was low is output unchanged.
- R3: A flagged sample whose following sample is good is replaced by floor((g + n) / 2). Here g is the channel's last good sample and n is the following sample, added as signed 17-bit values. This covers an isolated error, where g is the preceding sample, and extremes such as 32767 with 32767, which gives 32767.
- R4: A flagged sample whose following sample is also flagged is replaced by the channel's last good sample (a hold).
- R5: In a run of two or more flagged samples, the last one is replaced by the midpoint of the held value and the good sample that follows it.
- R6: Flags on one channel have no effect on the samples output on the other channel.
- R7: When `data_mode` is high at the strobe that releases a sample, that sample is output exactly as received, flagged or not, and `conceal_rpt` records no event for it.
- R8: After reset, `out_stb`, both outputs and `conceal_rpt` are zero. The first strobe outputs zero, and the last good value is zero, so a run of errors that begins at reset is held at zero.
- R9: `conceal_rpt` bit 0 means at least one interpolation (R3/R5), and bit 1 means at least one hold (R4). Both bits are sticky, take in the events of a strobe on the next clock, and cover both channels: 00 none, 01 interpolation only, 10 hold only, 11 both.
- R10: A `frame_start` pulse replaces the report with the events of that same cycle, or with 00 when there are none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe per word clock, marks a new sample pair |
| data_mode | input | 1 | High: non-audio content, concealment bypassed |
| frame_start | input | 1 | Starts a new report window |
| in_left | input | 16 | Left sample, two's complement |
| err_left | input | 1 | Left sample uncorrectable |
| in_right | input | 16 | Right sample, two's complement |
| err_right | input | 1 | Right sample uncorrectable |
| out_stb | output | 1 | Output pair valid for this cycle |
| out_left | output | 16 | Concealed left sample |
| out_right | output | 16 | Concealed right sample |
| conceal_rpt | output | 2 | Sticky concealment report for the frame window |

## Verification
The stimulus mixes clean streams, which show the fixed one-sample delay, with a single flagged sample between good neighbours, which shows midpoint replacement. A three-sample burst shows the difference between holding and interpolating the last sample of a run. Negative and full-scale neighbours test the floor rounding and the 17-bit sum. Errors are placed on one channel only to show the channels are independent. Flagged samples in data mode show the bypass. A burst straight after reset shows the zero hold value. Frame-start pulses, both alone and together with an event, separate clearing from accumulation in the report.

// File: rtl/conceal_pkg.sv
package conceal_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ACT_PASS   = 2'd0,
        ACT_INTERP = 2'd1,
        ACT_HOLD   = 2'd2
    } conceal_act_e;

    typedef struct packed {
        logic hold;
        logic interp;
    } conceal_ev_t;

    function automatic conceal_ev_t act_to_ev(conceal_act_e act);
        conceal_ev_t ev;
        ev.interp = (act == ACT_INTERP);
        ev.hold   = (act == ACT_HOLD);
        return ev;
    endfunction

endpackage

// File: rtl/conceal_chan.sv
module conceal_chan
    import conceal_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                bypass,
    input  logic signed [W-1:0] in_smp,
    input  logic                in_err,
    output logic signed [W-1:0] out_smp,
    output conceal_ev_t         ev
);
    localparam int SUM_W = W + 1;

    logic signed [W-1:0]     cur_q;
    logic                    cur_err_q;
    logic signed [W-1:0]     good_q;
    logic signed [W-1:0]     out_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [W-1:0]     mid;
    logic signed [W-1:0]     sel;
    conceal_act_e            act;

    always_comb begin
        sum = {good_q[W-1], good_q} + {in_smp[W-1], in_smp};
        mid = sum[SUM_W-1:1];
        if (bypass || !cur_err_q) begin
            act = ACT_PASS;
        end else if (in_err) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_INTERP;
        end
        case (act)
            ACT_HOLD:   sel = good_q;
            ACT_INTERP: sel = mid;
            default:    sel = cur_q;
        endcase
        ev = stb ? act_to_ev(act) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            cur_err_q <= 1'b0;
            good_q    <= '0;
            out_q     <= '0;
        end else if (stb) begin
            out_q     <= sel;
            if (!cur_err_q) begin
                good_q <= cur_q;
            end
            cur_q     <= in_smp;
            cur_err_q <= in_err;
        end
    end

    assign out_smp = out_q;

endmodule

// File: rtl/conceal_report.sv
module conceal_report
    import conceal_pkg::*;
#(
    parameter int N = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  conceal_ev_t ev [N],
    output logic [1:0]  rpt
);
    logic [1:0] rpt_q;
    logic       any_interp;
    logic       any_hold;

    always_comb begin
        any_interp = 1'b0;
        any_hold   = 1'b0;
        for (int i = 0; i < N; i++) begin
            any_interp = any_interp | ev[i].interp;
            any_hold   = any_hold   | ev[i].hold;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_q <= 2'b00;
        end else if (frame_start) begin
            rpt_q <= {any_hold, any_interp};
        end else begin
            rpt_q <= rpt_q | {any_hold, any_interp};
        end
    end

    assign rpt = rpt_q;

endmodule

// File: rtl/conceal_interp.sv
module conceal_interp
    import conceal_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_stb,
    input  logic                       data_mode,
    input  logic                       frame_start,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic                       err_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic                       err_right,
    output logic                       out_stb,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic [1:0]                 conceal_rpt
);
    logic signed [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic                       ch_err [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_out [NUM_CH];
    conceal_ev_t                ch_ev  [NUM_CH];
    logic                       stb_q;

    assign ch_in[0]  = in_left;
    assign ch_in[1]  = in_right;
    assign ch_err[0] = err_left;
    assign ch_err[1] = err_right;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        conceal_chan #(.W(SAMPLE_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .stb     (smp_stb),
            .bypass  (data_mode),
            .in_smp  (ch_in[c]),
            .in_err  (ch_err[c]),
            .out_smp (ch_out[c]),
            .ev      (ch_ev[c])
        );
    end

    conceal_report #(.N(NUM_CH)) u_report (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .ev          (ch_ev),
        .rpt         (conceal_rpt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= smp_stb;
        end
    end

    assign out_stb   = stb_q;
    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

endmodule

// File: rtl/conceal_interp_chk.sv
module conceal_interp_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       smp_stb,
    input logic                       data_mode,
    input logic                       frame_start,
    input logic signed [SAMPLE_W-1:0] in_left,
    input logic                       err_left,
    input logic                       out_stb,
    input logic signed [SAMPLE_W-1:0] out_left,
    input logic signed [SAMPLE_W-1:0] out_right,
    input logic [1:0]                 conceal_rpt
);
    logic signed [SAMPLE_W-1:0] seen_l;
    logic                       seen_err;
    logic                       seen_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_l   <= '0;
            seen_err <= 1'b0;
            seen_v   <= 1'b0;
        end else if (smp_stb) begin
            seen_l   <= in_left;
            seen_err <= err_left;
            seen_v   <= 1'b1;
        end
    end

    // R1
    stb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> out_stb);

    // R1
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> (!out_stb && $stable(out_left) && $stable(out_right)));

    // R2
    good_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && seen_v && !seen_err) |=> (out_left == $past(seen_l)));

    // R7
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && data_mode && !frame_start) |=> (conceal_rpt == $past(conceal_rpt)));

    // R9
    interp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && conceal_rpt[0]) |=> conceal_rpt[0]);

    // R9
    hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && conceal_rpt[1]) |=> conceal_rpt[1]);

    // R10
    window_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !smp_stb) |=> (conceal_rpt == 2'b00));

endmodule

bind conceal_interp conceal_interp_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_stb     (smp_stb),
    .data_mode   (data_mode),
    .frame_start (frame_start),
    .in_left     (in_left),
    .err_left    (err_left),
    .out_stb     (out_stb),
    .out_left    (out_left),
    .out_right   (out_right),
    .conceal_rpt (conceal_rpt)
);

// File: tb/conceal_interp_test.sv
module conceal_interp_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_stb = 1'b0;
    logic               data_mode = 1'b0;
    logic               frame_start = 1'b0;
    logic signed [15:0] in_left = '0;
    logic               err_left = 1'b0;
    logic signed [15:0] in_right = '0;
    logic               err_right = 1'b0;
    logic               out_stb;
    logic signed [15:0] out_left;
    logic signed [15:0] out_right;
    logic [1:0]         conceal_rpt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_cur [2];
    bit m_err [2];
    int m_good [2];
    int m_out [2];
    int m_rpt;

    always #5 clk = ~clk;

    conceal_interp uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .data_mode(data_mode),
        .frame_start(frame_start), .in_left(in_left), .err_left(err_left),
        .in_right(in_right), .err_right(err_right), .out_stb(out_stb),
        .out_left(out_left), .out_right(out_right), .conceal_rpt(conceal_rpt)
    );

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cur[c] = 0; m_err[c] = 0; m_good[c] = 0; m_out[c] = 0;
        end
        m_rpt = 0;
    endtask

    task automatic compare(string tag, bit exp_stb);
        chk({tag, " out_stb"}, int'(out_stb), int'(exp_stb));
        chk({tag, " left"}, int'(out_left), m_out[0]);
        chk({tag, " right"}, int'(out_right), m_out[1]);
        chk({tag, " report"}, int'(conceal_rpt), m_rpt);
    endtask

    task automatic step(int l, bit el, int r, bit er, bit dm, bit fs, string tag);
        int nv [2];
        bit ne [2];
        int ev;
        nv[0] = l; nv[1] = r; ne[0] = el; ne[1] = er;
        ev = 0;
        for (int c = 0; c < 2; c++) begin
            if (dm || !m_err[c]) begin
                m_out[c] = m_cur[c];
            end else if (ne[c]) begin
                m_out[c] = m_good[c];
                ev = ev | 2;
            end else begin
                m_out[c] = (m_good[c] + nv[c]) >>> 1;
                ev = ev | 1;
            end
            if (!m_err[c]) m_good[c] = m_cur[c];
            m_cur[c] = nv[c];
            m_err[c] = ne[c];
        end
        m_rpt = fs ? ev : (m_rpt | ev);
        in_left = 16'(l); err_left = el; in_right = 16'(r); err_right = er;
        data_mode = dm; frame_start = fs; smp_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_stb = 1'b0; frame_start = 1'b0; err_left = 1'b0; err_right = 1'b0;
        compare(tag, 1'b1);
        @(posedge clk);
        @(negedge clk);
        compare({tag, " idle"}, 1'b0);
    endtask

    task automatic frame_pulse(string tag);
        frame_start = 1'b1;
        m_rpt = 0;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0;
        compare(tag, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R8 reset state", 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1/R8: first output carries the reset value
        step(100, 0, -200, 0, 0, 0, "R1 R8 first strobe");
        step(300, 0, 5, 0, 0, 0, "R2 clean");
        step(-7, 0, 9, 0, 0, 0, "R2 clean");
        // R3 isolated error on left only, R6 right clean
        step(1000, 1, 40, 0, 0, 0, "R3 R6 isolated");
        step(500, 0, 41, 0, 0, 0, "R3 R6 isolated");
        step(-3, 0, 42, 0, 0, 0, "R3 R9 interp");
        frame_pulse("R10 clear alone");
        // R3 negative floor: last good -3, next 0 -> -2
        step(77, 1, 43, 0, 0, 0, "R3 floor");
        step(0, 0, 44, 0, 0, 0, "R3 floor");
        step(1, 0, 45, 0, 0, 0, "R3 floor");
        frame_pulse("R10 clear");
        // R4/R5 burst of three on right
        step(2, 0, 1000, 1, 0, 0, "R4 burst");
        step(3, 0, 2000, 1, 0, 0, "R4 R9 hold");
        step(4, 0, 3000, 1, 0, 0, "R4 hold");
        step(5, 0, -600, 0, 0, 0, "R5 R9 end interp");
        step(6, 0, 7, 0, 0, 0, "R5 after");
        // R3 full scale
        step(32767, 0, -32768, 0, 0, 0, "R3 extreme");
        step(11, 1, 12, 1, 0, 0, "R3 extreme");
        step(32767, 0, -32768, 0, 0, 0, "R3 extreme");
        step(0, 0, 0, 0, 0, 0, "R3 extreme");
        frame_pulse("R10 clear");
        // R7 data mode passes flagged values raw
        step(1234, 1, -4321, 1, 1, 0, "R7 bypass");
        step(555, 1, 666, 0, 1, 0, "R7 bypass");
        step(8, 0, 9, 0, 1, 0, "R7 bypass");
        step(10, 0, 11, 0, 0, 0, "R7 after");
        // R10 frame start together with a hold event
        step(20, 1, 21, 0, 0, 0, "R10 setup");
        step(22, 1, 23, 0, 0, 1, "R10 same cycle");
        step(24, 0, 25, 0, 0, 0, "R10 R9 both");
        // R8 burst straight after reset is held at zero
        do_reset();
        step(900, 1, 50, 0, 0, 0, "R8 reset burst");
        step(901, 1, 51, 0, 0, 0, "R8 hold zero");
        step(400, 0, 52, 0, 0, 0, "R8 interp from zero");
        step(401, 0, 53, 0, 0, 0, "R8 after");
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule